// File: doc/BRIEF.md
# Configurable Interrupt Pin Driver

This block turns an internal interrupt-pending flag into the level on an external interrupt pin. A 2-bit run-time mode picks one of four pin styles. Two are held levels: the pin is active low or active high for as long as the flag is set. Two are pulses: the line idles high and drops for a set time, or it idles low and rises for a set time. The pulse width comes from an input setting, counted in clocks.

Logic outside the block detects, masks and records interrupt sources. This block only shapes the waveform on the pin. It also reacts cleanly when the mode is changed while it is running: any pulse in progress is dropped and the pin goes to the rest level of the new mode. The pin is registered, so it changes one clock after the inputs that cause it.

Top module: `irq_pin_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_pin` is 1 after that edge, and the mode tracked internally is 00.
- R2: Mode encoding: bit 1 selects pulse (1) or level (0) style, and bit 0 selects active-high or rising (1) versus active-low or falling (0). In mode 00, with the mode unchanged since the previous clock, `irq_pin` after an edge equals the inverse of `irq_pending` sampled at that edge.
- R3: In mode 01, with the mode unchanged, `irq_pin` after an edge equals `irq_pending` sampled at that edge.
- R4: In mode 10, the pin rests at 1. A rising edge of `irq_pending` drives it to 0 from the next clock.
- R5: In mode 11, the pin rests at 0. A rising edge of `irq_pending` drives it to 1 from the next clock.
- R6: In the two pulse modes, a pulse stays active for exactly `pulse_len` clocks and then returns to rest. A `pulse_len` of 0 is treated as 1.
- R7: When `mode` differs from its value at the previous edge, `irq_pin` takes the rest level of the new mode (the inverse of mode bit 0) on that clock, and any pulse in progress is abandoned.
- R8: In the pulse modes, an `irq_pending` that stays high makes no further pulse. Only a fall followed by a new rise starts another pulse, and a rise during a pulse restarts the full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Pin style: bit 1 = pulse style, bit 0 = active-high or rising polarity |
| irq_pending | input | 1 | Internal interrupt-pending flag |
| pulse_len | input | PULSE_W | Pulse width in clocks for the pulse modes (0 acts as 1) |
| irq_pin | output | 1 | Registered level driven onto the interrupt pin |

## Verification
A mode change and a pulse event can land on the same clock. A new rising edge of the pending flag, or the last clock of a running pulse, can coincide with a write to the mode bits. In that case the mode change must win: the pin goes to the new rest level and the timer is cleared. The bench provokes this directly by changing the mode in the cycle where the pending flag rises and again part-way through a pulse. Random mode flips then land on arbitrary pulse phases. Each pin value is judged against a clock-level model built from the requirements, which gives the mode change priority over every pulse event.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;

   typedef enum logic [1:0] {
      PIN_LEVEL_LOW  = 2'b00,
      PIN_LEVEL_HIGH = 2'b01,
      PIN_PULSE_FALL = 2'b10,
      PIN_PULSE_RISE = 2'b11
   } pin_mode_e;

   // Rest level of a mode: low-polarity styles idle high.
   function automatic logic rest_level(input logic [1:0] m);
      return ~m[0];
   endfunction

   function automatic logic is_pulse_mode(input logic [1:0] m);
      return m[1];
   endfunction

endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track
   import irq_pin_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode,
   input  logic       pending,
   output logic       mode_chg,
   output logic       pend_rise
);

   pin_mode_e mode_q;
   logic      pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= PIN_LEVEL_LOW;
         pend_q <= 1'b0;
      end else begin
         mode_q <= pin_mode_e'(mode);
         pend_q <= pending;
      end
   end

   assign mode_chg  = (mode != mode_q);
   assign pend_rise = pending & ~pend_q;

   // R1: the tracked mode is the default level style right after reset
   a_r1_mode_default: assert property (@(posedge clk)
      rst |=> (mode_q == PIN_LEVEL_LOW));

endmodule

// File: rtl/irq_pin_pulse_timer.sv
module irq_pin_pulse_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             abort,
   input  logic [CNT_W-1:0] len,
   output logic             busy
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] eff_len;

   assign eff_len = (len == ZERO) ? ONE : len;

   always_ff @(posedge clk) begin
      if (rst || abort) begin
         remain <= ZERO;
      end else if (start) begin
         remain <= eff_len - ONE;
      end else if (remain != ZERO) begin
         remain <= remain - ONE;
      end
   end

   assign busy = (remain != ZERO);

   // R7: an abort leaves no pulse time behind
   a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
      abort |=> !busy);

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper
   import irq_pin_pkg::*;
#(
   parameter int unsigned PULSE_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [1:0]         mode,
   input  logic               irq_pending,
   input  logic [PULSE_W-1:0] pulse_len,
   output logic               irq_pin
);

   localparam int unsigned MAX_PULSE_W = 16;

   generate
      if (PULSE_W < 1 || PULSE_W > MAX_PULSE_W) begin : g_bad_width
         $error("irq_pin_shaper: PULSE_W out of range");
      end
   endgenerate

   logic mode_chg;
   logic pend_rise;
   logic timer_busy;
   logic timer_start;
   logic timer_abort;
   logic pin_nx;

   irq_pin_track u_track (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode),
      .pending   (irq_pending),
      .mode_chg  (mode_chg),
      .pend_rise (pend_rise)
   );

   // A mode change always takes priority over any pulse event in the same cycle.
   assign timer_abort = mode_chg | ~is_pulse_mode(mode);
   assign timer_start = ~timer_abort & pend_rise;

   irq_pin_pulse_timer #(.CNT_W(PULSE_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (timer_start),
      .abort (timer_abort),
      .len   (pulse_len),
      .busy  (timer_busy)
   );

   always_comb begin
      if (mode_chg) begin
         pin_nx = rest_level(mode);
      end else if (!is_pulse_mode(mode)) begin
         pin_nx = mode[0] ? irq_pending : ~irq_pending;
      end else if (timer_start || timer_busy) begin
         pin_nx = ~rest_level(mode);
      end else begin
         pin_nx = rest_level(mode);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_pin <= 1'b1;
      end else begin
         irq_pin <= pin_nx;
      end
   end

   // R1: reset holds the pin at the idle level of the default style
   a_r1_reset_high: assert property (@(posedge clk)
      rst |=> irq_pin);

   // R2, R3: level styles follow the pending flag with the selected polarity
   a_r2_level_follow: assert property (@(posedge clk) disable iff (rst)
      (!mode_chg && !mode[1]) |=> (irq_pin == ($past(mode[0]) ~^ $past(irq_pending))));

   // R7: a mode change parks the pin at the new rest level
   a_r7_rest_after_change: assert property (@(posedge clk) disable iff (rst)
      mode_chg |=> (irq_pin == ~$past(mode[0])));

   // R6: while pulse time remains the pin stays active
   a_r6_hold_active: assert property (@(posedge clk) disable iff (rst)
      (timer_busy && !mode_chg && mode[1]) |=> (irq_pin == $past(mode[0])));

   // R8: at rest in a pulse style, no rise means no pulse
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
      (mode[1] && !mode_chg && !pend_rise && (irq_pin == ~mode[0]))
         |=> (irq_pin == ~$past(mode[0])));

endmodule

// File: tb/test_irq_pin_shaper.sv
module test_irq_pin_shaper;

   localparam int unsigned PW = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode = 2'b00;
   logic          irq_pending = 1'b0;
   logic [PW-1:0] pulse_len = '0;
   logic          irq_pin;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   // clock-level reference, written from the requirements
   logic          m_pin;
   logic [1:0]    m_mode;
   logic          m_pend;
   int            m_left;
   string         m_tag;

   always #2 clk = ~clk;

   irq_pin_shaper #(.PULSE_W(PW)) i_irq_pin_shaper (
      .clk         (clk),
      .rst         (rst),
      .mode        (mode),
      .irq_pending (irq_pending),
      .pulse_len   (pulse_len),
      .irq_pin     (irq_pin)
   );

   function automatic int eff_len(input logic [PW-1:0] l);
      return (l == '0) ? 1 : int'(l);
   endfunction

   task automatic model_step(input logic [1:0] md, input logic pd, input logic [PW-1:0] ln);
      logic rise;
      rise = pd & ~m_pend;
      if (md != m_mode) begin
         m_pin = ~md[0]; m_left = 0; m_tag = "R7";
      end else if (!md[1]) begin
         m_pin = md[0] ? pd : ~pd; m_left = 0;
         m_tag = md[0] ? "R3" : "R2";
      end else if (rise) begin
         m_pin = md[0]; m_left = eff_len(ln) - 1;
         m_tag = md[0] ? "R5" : "R4";
      end else if (m_left != 0) begin
         m_pin = md[0]; m_left = m_left - 1; m_tag = "R6";
      end else begin
         m_pin = ~md[0]; m_tag = "R8";
      end
      m_mode = md;
      m_pend = pd;
   endtask

   task automatic check_pin(input string tag);
      checks++;
      if (irq_pin !== m_pin) begin
         failures++;
         $display("FAIL %s: irq_pin=%b expected=%b at %0t", tag, irq_pin, m_pin, $time);
      end
   endtask

   // compare the pin set by the previous edge, then drive inputs for the next edge
   task automatic cyc(input logic [1:0] md, input logic pd, input logic [PW-1:0] ln);
      @(negedge clk);
      check_pin(m_tag);
      mode = md; irq_pending = pd; pulse_len = ln;
      model_step(md, pd, ln);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      checks++;
      if (irq_pin !== 1'b1) begin
         failures++;
         $display("FAIL R1: irq_pin=%b expected=1 in reset", irq_pin);
      end
      m_pin = 1'b1; m_mode = 2'b00; m_pend = 1'b0; m_left = 0; m_tag = "R1";
      rst = 1'b0;
      model_step(2'b00, 1'b0, '0);
      m_tag = "R1";

      // R2 level low-active
      cyc(2'b00, 1'b1, 4'd2);
      cyc(2'b00, 1'b0, 4'd2);
      // R3 (mode change first, R7)
      cyc(2'b01, 1'b1, 4'd2);
      cyc(2'b01, 1'b1, 4'd2);
      cyc(2'b01, 1'b0, 4'd2);
      // R4 + R6: falling pulse width 3, R8 held pending
      cyc(2'b10, 1'b0, 4'd3);
      cyc(2'b10, 1'b1, 4'd3);
      for (int i = 0; i < 6; i++) cyc(2'b10, 1'b1, 4'd3);
      // R6: zero width acts as one
      cyc(2'b10, 1'b0, 4'd0);
      cyc(2'b10, 1'b1, 4'd0);
      cyc(2'b10, 1'b1, 4'd0);
      cyc(2'b10, 1'b1, 4'd0);
      // R8 retrigger during pulse restarts width
      cyc(2'b10, 1'b0, 4'd4);
      cyc(2'b10, 1'b1, 4'd4);
      cyc(2'b10, 1'b0, 4'd4);
      cyc(2'b10, 1'b1, 4'd4);
      for (int i = 0; i < 5; i++) cyc(2'b10, 1'b1, 4'd4);
      // R5 rising pulse then R7 change mid-pulse
      cyc(2'b11, 1'b0, 4'd6);
      cyc(2'b11, 1'b1, 4'd6);
      cyc(2'b11, 1'b1, 4'd6);
      cyc(2'b10, 1'b1, 4'd6);
      cyc(2'b10, 1'b1, 4'd6);
      // R7 change in the same cycle as a pending rise
      cyc(2'b10, 1'b0, 4'd2);
      cyc(2'b11, 1'b1, 4'd2);
      cyc(2'b11, 1'b1, 4'd2);
      cyc(2'b11, 1'b1, 4'd2);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [1:0]    md;
         logic          pd;
         logic [PW-1:0] ln;
         md = ($urandom_range(0, 29) == 0) ? 2'($urandom_range(0, 3)) : mode;
         pd = ($urandom_range(0, 3) == 0) ? ~irq_pending : irq_pending;
         ln = ($urandom_range(0, 4) == 0) ? PW'($urandom_range(0, 7)) : pulse_len;
         cyc(md, pd, ln);
      end
      @(negedge clk);
      check_pin(m_tag);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule